// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and drives two processor request lines: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line has its own enable mask, so one source can be routed to either line, to both or to neither. A line is high while at least one source is both active and enabled for that line. No priority, vector or edge logic sits between the sources and the lines.

Software reaches the block through a simple word-indexed access port. A request strobe with a write flag, a word index and write data is taken on one clock edge. Read data appears on `rsp_rdata` in the following cycle. The index map gives a masked and a raw view of the source levels for each line, set and clear addresses for each enable mask, and a pair of set and clear addresses that force source 0 from software. An access to an index that is unmapped or not legal in that direction changes no state and raises a one-cycle error strobe.

Top module: `intc_dual`

## Requirements
- R1: Source level bit i follows `src_i[i]` one clock later. Reading index 1 or index 9 returns the full level vector, with bit i holding source i.
- R2: `irq_o` is high exactly when (level AND normal enable) is non-zero, and `fiq_o` is high exactly when (level AND fast enable) is non-zero. Both reflect the state set up by the most recent clock edge, so they move one cycle after any level or enable change.
- R3: Reading index 0 returns level AND normal enable. Reading index 8 returns level AND fast enable.
- R4: Writing index 2 ORs the data into the normal enable mask. Writing index 3 clears every mask bit that is 1 in the data. Reading index 2 returns the mask.
- R5: Index 10 (set), index 11 (clear) and index 10 (read) act on the fast enable mask in the same way, and leave the normal mask untouched.
- R6: Writing index 4 with data bit 0 = 1 latches a software request on source 0. Level bit 0 is then 1 whatever `src_i[0]` does, until index 5 is written with data bit 0 = 1. A write to index 4 or 5 with data bit 0 = 0 has no effect. Reading index 4 returns level bit 0 in bit 0 and zero in bits 31..1.
- R7: Reads of indices 3, 5 and 11, and reads of unmapped indices (6, 7 and 12 and above), return zero. Writes to indices 0, 1, 8 and 9, and writes to unmapped indices, change no enable mask and no software request.
- R8: `err_o` is high for exactly one cycle, in the cycle after an access that R7 calls illegal, and is low in every other cycle.
- R9: While reset is held, and right after it is released, both enable masks and the software request are zero, and `irq_o`, `fiq_o`, `err_o` and `rsp_rdata` are zero.
- R10: `rsp_rdata` changes only in the cycle after a read request, and shows the state as it stood at the request edge. In all other cycles it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | NUM_SRC | Source levels, bit i is source i |
| req_valid | input | 1 | Access request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | IDX_W | Word index of the access |
| req_wdata | input | NUM_SRC | Write data |
| rsp_rdata | output | NUM_SRC | Read data, valid the cycle after a read |
| err_o | output | 1 | One-cycle strobe for an illegal or unmapped access |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench first goes after the software request on source 0. A design that simply copies the input would drop the request as soon as `src_i[0]` goes low. A design that ignores data bit 0 on the set and clear indices would raise or drop the request on any write to them. The second target is the pair of direction-illegal indices. A design that decoded only the index, and not the direction, would let a write to a status index touch a mask, or would return live data when a clear index is read. Random traffic over the whole index space, with the inputs changing in between, checks that the two masks stay independent and that `err_o` never fires on a legal access and never stays high.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int IDX_CODE_W = 16;
  typedef logic [IDX_CODE_W-1:0] idx_t;

  // Word index map (behaviour depends on these values)
  localparam idx_t IX_IRQ_MSK = 16'd0;
  localparam idx_t IX_RAW_A   = 16'd1;
  localparam idx_t IX_IRQ_EN  = 16'd2;
  localparam idx_t IX_IRQ_OFF = 16'd3;
  localparam idx_t IX_SW_ON   = 16'd4;
  localparam idx_t IX_SW_OFF  = 16'd5;
  localparam idx_t IX_FIQ_MSK = 16'd8;
  localparam idx_t IX_RAW_B   = 16'd9;
  localparam idx_t IX_FIQ_EN  = 16'd10;
  localparam idx_t IX_FIQ_OFF = 16'd11;

  // Decoded write commands, one strobe per state-changing action
  typedef struct packed {
    logic irq_on;
    logic irq_off;
    logic fiq_on;
    logic fiq_off;
    logic sw_on;
    logic sw_off;
  } wr_cmd_t;

  function automatic logic rd_legal(idx_t i);
    return (i == IX_IRQ_MSK) || (i == IX_RAW_A) || (i == IX_IRQ_EN) ||
           (i == IX_SW_ON)   || (i == IX_FIQ_MSK) || (i == IX_RAW_B) ||
           (i == IX_FIQ_EN);
  endfunction

  function automatic logic wr_legal(idx_t i);
    return (i == IX_IRQ_EN) || (i == IX_IRQ_OFF) || (i == IX_SW_ON) ||
           (i == IX_SW_OFF) || (i == IX_FIQ_EN)  || (i == IX_FIQ_OFF);
  endfunction

endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_o
);

  logic [W-1:0] en_q;
  logic [W-1:0] en_d;

  // OR-in on set, knock out written ones on clear
  function automatic logic [W-1:0] next_mask(input logic [W-1:0] cur,
                                             input logic [W-1:0] val,
                                             input logic s,
                                             input logic c);
    logic [W-1:0] r;
    r = cur;
    if (s) r = r | val;
    if (c) r = r & ~val;
    return r;
  endfunction

  always_comb en_d = next_mask(en_q, wdata, set_stb, clr_stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

endmodule

// File: rtl/intc_level_stage.sv
module intc_level_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         sw_on,
  input  logic         sw_off,
  output logic [W-1:0] level_o,
  output logic         sw_o
);

  logic         sw_q;
  logic         sw_d;
  logic [W-1:0] level_q;
  logic [W-1:0] level_d;

  // Software request on source 0: sticky until explicitly cleared
  always_comb begin
    sw_d = sw_q;
    if (sw_on)       sw_d = 1'b1;
    else if (sw_off) sw_d = 1'b0;
  end

  always_comb begin
    level_d    = src_i;
    level_d[0] = src_i[0] | sw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q    <= 1'b0;
      level_q <= '0;
    end else begin
      sw_q    <= sw_d;
      level_q <= level_d;
    end
  end

  assign level_o = level_q;
  assign sw_o    = sw_q;

endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [W-1:0]     req_wdata,
  input  logic [W-1:0]     level,
  input  logic [W-1:0]     irq_en,
  input  logic [W-1:0]     fiq_en,
  output wr_cmd_t          cmd,
  output logic [W-1:0]     rdata_o,
  output logic             err_o
);

  idx_t         ix;
  logic         rd_req;
  logic         wr_req;
  logic         bad_acc;
  logic [W-1:0] rd_val;
  logic [W-1:0] rdata_q;
  logic         err_q;

  always_comb begin
    ix = '0;
    ix[IDX_W-1:0] = req_idx;
  end

  assign rd_req  = req_valid && !req_write;
  assign wr_req  = req_valid &&  req_write;
  assign bad_acc = (rd_req && !rd_legal(ix)) || (wr_req && !wr_legal(ix));

  function automatic logic [W-1:0] read_value(input idx_t i,
                                              input logic [W-1:0] lv,
                                              input logic [W-1:0] ie,
                                              input logic [W-1:0] fe);
    logic [W-1:0] r;
    r = '0;
    case (i)
      IX_IRQ_MSK: r = lv & ie;
      IX_RAW_A:   r = lv;
      IX_IRQ_EN:  r = ie;
      IX_SW_ON:   r[0] = lv[0];
      IX_FIQ_MSK: r = lv & fe;
      IX_RAW_B:   r = lv;
      IX_FIQ_EN:  r = fe;
      default:    r = '0;
    endcase
    return r;
  endfunction

  always_comb rd_val = read_value(ix, level, irq_en, fiq_en);

  always_comb begin
    cmd         = '0;
    cmd.irq_on  = wr_req && (ix == IX_IRQ_EN);
    cmd.irq_off = wr_req && (ix == IX_IRQ_OFF);
    cmd.fiq_on  = wr_req && (ix == IX_FIQ_EN);
    cmd.fiq_off = wr_req && (ix == IX_FIQ_OFF);
    cmd.sw_on   = wr_req && (ix == IX_SW_ON)  && req_wdata[0];
    cmd.sw_off  = wr_req && (ix == IX_SW_OFF) && req_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= bad_acc;
      if (rd_req) rdata_q <= rd_val;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

endmodule

// File: rtl/intc_dual.sv
module intc_dual
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic [NUM_SRC-1:0] req_wdata,
  output logic [NUM_SRC-1:0] rsp_rdata,
  output logic               err_o,
  output logic               irq_o,
  output logic               fiq_o
);

  localparam int N_BANK = 2;  // 0 = normal, 1 = fast

  wr_cmd_t            cmd;
  logic [NUM_SRC-1:0] level_q;
  logic               sw_q;
  logic [NUM_SRC-1:0] irq_en;
  logic [NUM_SRC-1:0] fiq_en;
  logic [NUM_SRC-1:0] bank_en  [N_BANK];
  logic               bank_set [N_BANK];
  logic               bank_clr [N_BANK];
  logic               irq_hit;
  logic               fiq_hit;

  intc_regif #(.W(NUM_SRC), .IDX_W(IDX_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_idx   (req_idx),
    .req_wdata (req_wdata),
    .level     (level_q),
    .irq_en    (irq_en),
    .fiq_en    (fiq_en),
    .cmd       (cmd),
    .rdata_o   (rsp_rdata),
    .err_o     (err_o)
  );

  intc_level_stage #(.W(NUM_SRC)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_i),
    .sw_on   (cmd.sw_on),
    .sw_off  (cmd.sw_off),
    .level_o (level_q),
    .sw_o    (sw_q)
  );

  always_comb begin
    bank_set[0] = cmd.irq_on;
    bank_clr[0] = cmd.irq_off;
    bank_set[1] = cmd.fiq_on;
    bank_clr[1] = cmd.fiq_off;
  end

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    intc_mask_bank #(.W(NUM_SRC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (bank_set[g]),
      .clr_stb (bank_clr[g]),
      .wdata   (req_wdata),
      .en_o    (bank_en[g])
    );
  end

  assign irq_en  = bank_en[0];
  assign fiq_en  = bank_en[1];

  // Outputs depend on flops only: they move one cycle after any change
  assign irq_hit = |(level_q & irq_en);
  assign fiq_hit = |(level_q & fiq_en);
  assign irq_o   = irq_hit;
  assign fiq_o   = fiq_hit;

endmodule

// File: rtl/intc_dual_chk.sv
module intc_dual_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [IDX_W-1:0]   req_idx,
  input logic [NUM_SRC-1:0] req_wdata,
  input logic [NUM_SRC-1:0] rsp_rdata,
  input logic               err_o,
  input logic [NUM_SRC-1:0] irq_en,
  input logic [NUM_SRC-1:0] fiq_en,
  input logic [NUM_SRC-1:0] level_q,
  input logic               sw_q
);

  idx_t ix;
  always_comb begin
    ix = '0;
    ix[IDX_W-1:0] = req_idx;
  end

  logic wr_bad;
  logic rd_bad;
  assign wr_bad = req_valid &&  req_write && !wr_legal(ix);
  assign rd_bad = req_valid && !req_write && !rd_legal(ix);

  // R4
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && ix == IX_IRQ_EN) |=>
      ((irq_en & $past(req_wdata)) == $past(req_wdata)));

  // R4
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && ix == IX_IRQ_OFF) |=>
      ((irq_en & $past(req_wdata)) == '0));

  // R5
  fiq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && ix == IX_FIQ_EN) |=>
      ((fiq_en & $past(req_wdata)) == $past(req_wdata)) && $stable(irq_en));

  // R5
  fiq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && ix == IX_FIQ_OFF) |=>
      ((fiq_en & $past(req_wdata)) == '0) && $stable(irq_en));

  // R6
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q && !(req_valid && req_write && ix == IX_SW_OFF && req_wdata[0])) |=>
      (sw_q && level_q[0]));

  // R7
  bad_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> ($stable(irq_en) && $stable(fiq_en) && $stable(sw_q)));

  // R7
  bad_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |=> (rsp_rdata == '0));

  // R8
  err_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bad || rd_bad) |=> err_o);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_bad || rd_bad) |=> !err_o);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rsp_rdata));

endmodule

bind intc_dual intc_dual_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_idx   (req_idx),
  .req_wdata (req_wdata),
  .rsp_rdata (rsp_rdata),
  .err_o     (err_o),
  .irq_en    (irq_en),
  .fiq_en    (fiq_en),
  .level_q   (level_q),
  .sw_q      (sw_q)
);

// File: tb/sim_intc_dual.sv
`timescale 1ns/1ps
module sim_intc_dual;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        err_o, irq_o, fiq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the block state
  logic [31:0] m_ie = '0;
  logic [31:0] m_fe = '0;
  bit          m_sw = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  intc_dual #(.NUM_SRC(32), .IDX_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .req_valid(req_valid), .req_write(req_write), .req_idx(req_idx),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .err_o(err_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_level();
    logic [31:0] l;
    l = src_i;
    l[0] = src_i[0] | m_sw;
    return l;
  endfunction

  function automatic bit ok_rd(input int i);
    return i == 0 || i == 1 || i == 2 || i == 4 || i == 8 || i == 9 || i == 10;
  endfunction

  function automatic bit ok_wr(input int i);
    return i == 2 || i == 3 || i == 4 || i == 5 || i == 10 || i == 11;
  endfunction

  function automatic logic [31:0] m_read(input int i, input logic [31:0] l);
    case (i)
      0:       return l & m_ie;
      1, 9:    return l;
      2:       return m_ie;
      4:       return {31'b0, l[0]};
      8:       return l & m_fe;
      10:      return m_fe;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input int i);
    if (!ok_rd(i)) return "R7";
    case (i)
      0, 8:  return "R3";
      1, 9:  return "R1";
      2:     return "R4";
      10:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_lines();
    logic [31:0] l;
    l = m_level();
    check(irq_o == |(l & m_ie), "R2 irq", {31'b0, irq_o}, {31'b0, |(l & m_ie)});
    check(fiq_o == |(l & m_fe), "R2 fiq", {31'b0, fiq_o}, {31'b0, |(l & m_fe)});
  endtask

  // one access; returns with the result sampled at the following negedge
  task automatic access(input bit wr, input int idx, input logic [31:0] d);
    logic [31:0] exp_rd;
    bit legal;
    @(negedge clk);
    legal  = wr ? ok_wr(idx) : ok_rd(idx);
    exp_rd = wr ? rsp_rdata : m_read(idx, m_level());
    req_valid = 1'b1; req_write = wr; req_idx = idx[5:0]; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      case (idx)
        2:  m_ie = m_ie | d;
        3:  m_ie = m_ie & ~d;
        4:  if (d[0]) m_sw = 1'b1;
        5:  if (d[0]) m_sw = 1'b0;
        10: m_fe = m_fe | d;
        11: m_fe = m_fe & ~d;
        default: ;
      endcase
    end
    check(err_o == !legal, "R8", {31'b0, err_o}, {31'b0, !legal});
    if (wr) check(rsp_rdata == exp_rd, "R10 hold on write", rsp_rdata, exp_rd);
    else    check(rsp_rdata == exp_rd, tag_of(idx), rsp_rdata, exp_rd);
    check_lines();
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk);
    src_i = v;
    @(negedge clk);
    check_lines();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: state during reset
    check(irq_o == 1'b0 && fiq_o == 1'b0, "R9 lines", {30'b0, irq_o, fiq_o}, '0);
    check(err_o == 1'b0, "R9 err", {31'b0, err_o}, '0);
    check(rsp_rdata == '0, "R9 rdata", rsp_rdata, '0);
    rst_n = 1'b1;
    src_i = 32'hFFFF_FFFF;
    @(negedge clk);
    check(irq_o == 1'b0 && fiq_o == 1'b0, "R9 lines after release",
          {30'b0, irq_o, fiq_o}, '0);
    access(1'b0, 2, '0);
    check(rsp_rdata == '0, "R9 irq mask zero", rsp_rdata, '0);
    access(1'b0, 10, '0);
    check(rsp_rdata == '0, "R9 fiq mask zero", rsp_rdata, '0);

    // R1 raw level, R4/R5 masks independent, R3 masked views
    drive_src(32'h8000_0012);
    access(1'b0, 1, '0);
    access(1'b1, 2, 32'h0000_0010);
    access(1'b1, 10, 32'h8000_0100);
    access(1'b0, 0, '0);
    access(1'b0, 8, '0);
    access(1'b0, 2, '0);
    access(1'b1, 3, 32'h0000_0010);
    access(1'b0, 2, '0);
    access(1'b0, 10, '0);
    access(1'b1, 11, 32'hFFFF_FFFF);
    drive_src(32'h0000_0000);

    // R6: software request on source 0
    access(1'b1, 2, 32'h0000_0001);
    access(1'b1, 4, 32'h0000_0002);        // bit0 = 0: no effect
    access(1'b0, 4, '0);
    check(rsp_rdata == 32'h0, "R6 set without bit0", rsp_rdata, 32'h0);
    access(1'b1, 4, 32'h0000_0001);
    access(1'b0, 4, '0);
    check(irq_o == 1'b1, "R6 request drives irq", {31'b0, irq_o}, 32'h1);
    drive_src(32'h0000_0001);
    drive_src(32'h0000_0000);
    access(1'b0, 1, '0);
    check(rsp_rdata[0] == 1'b1, "R6 held after input low", rsp_rdata, 32'h1);
    access(1'b1, 5, 32'h0000_0000);        // bit0 = 0: no effect
    access(1'b0, 4, '0);
    access(1'b1, 5, 32'h0000_0001);
    access(1'b0, 4, '0);
    check(rsp_rdata == 32'h0, "R6 cleared", rsp_rdata, 32'h0);

    // R7: direction-illegal and unmapped accesses
    access(1'b1, 0, 32'hFFFF_FFFF);
    access(1'b1, 9, 32'hFFFF_FFFF);
    access(1'b1, 40, 32'h0000_0001);
    access(1'b0, 2, '0);
    check(rsp_rdata == 32'h1, "R7 mask untouched", rsp_rdata, 32'h1);
    access(1'b0, 3, '0);
    access(1'b0, 11, '0);
    access(1'b0, 6, '0);

    // R10: read data holds while idle
    access(1'b0, 2, '0);
    @(negedge clk);
    check(rsp_rdata == 32'h1, "R10 hold while idle", rsp_rdata, 32'h1);

    // random traffic over the index space
    for (int k = 0; k < 600; k++) begin
      int sel;
      sel = $urandom_range(0, 7);
      if (sel == 0) drive_src($urandom());
      else begin
        int idx;
        logic [31:0] d;
        idx = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 63) : $urandom_range(0, 15);
        d = ($urandom_range(0, 3) == 0) ? {31'b0, 1'(sel[0])} : $urandom();
        access(1'($urandom_range(0, 1)), idx, d);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule